// File: doc/BRIEF.md
# Redundant Sensor Pair Validator

This block receives two redundant digitized readings of one process quantity, such as a pressure or a temperature. Each reading is a 16-bit converter code taken from a 4–20 mA current loop, and both arrive together under a sample strobe. Each reading is first checked against a programmable acceptance window. A reading outside that window is marked as faulted. Codes stuck at all zeros or all ones, which come from a loop that has failed low or high, always fall outside the window.

The number of healthy channels decides what happens next:

- **One channel faulted:** the healthy reading is passed through and an operator alarm is raised.
- **Both channels faulted:** the block trips into a latched safe state.
- **Neither channel faulted:** the two readings are cross-checked. If they differ by no more than a programmable deviation limit, the output is their average. If they differ by more, neither reading is trusted and the block trips into the safe state.

The safe state holds until a synchronous reset or an explicit clear. While it holds, every published value is the safe code.

Top module: `rspv_pair_validator`

## Requirements
- R1: A channel is flagged faulted when its code is below LO_LIM or above HI_LIM. Both limits count as in range. The defaults are LO_LIM = 10376 and HI_LIM = 55977, on a scale where code 65535 is 24 mA.
- R2: A code of 0 or 65535 on either channel is flagged faulted with the default limits.
- R3: When exactly one channel is faulted, the other channel's code is published unchanged and alarm is 1. Alarm is 0 whenever zero or two channels are faulted.
- R4: When both channels are faulted, safe becomes 1.
- R5: When neither channel is faulted and |A−B| ≤ DEV_LIM (default 1311), the published value is the 17-bit sum A+B shifted right by one, which truncates the result.
- R6: When neither channel is faulted and |A−B| > DEV_LIM, safe becomes 1.
- R7: Safe is latched. It clears only on rst or on a cycle with clr_safe high. A trip in the same cycle as clr_safe leaves safe at 1. Any sample published while safe is, or becomes, 1 carries SAFE_VAL (default 0).
- R8: All outputs are registered. The outputs out_val, flt_a, flt_b and alarm change only on the clock edge that samples smp_vld=1. The output out_vld is high for exactly the one cycle after each strobe.
- R9: After rst, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_safe | input | 1 | Releases the latched safe state |
| smp_vld | input | 1 | Strobe marking a new reading pair |
| code_a | input | 16 | Reading of channel A |
| code_b | input | 16 | Reading of channel B |
| out_val | output | 16 | Validated value |
| out_vld | output | 1 | Pulses one cycle after each strobe |
| flt_a | output | 1 | Channel A faulted on the last sample |
| flt_b | output | 1 | Channel B faulted on the last sample |
| alarm | output | 1 | Exactly one channel faulted on the last sample |
| safe | output | 1 | Latched safe state |

## Verification
Two functions can land in the same cycle: a trip from a fresh sample, and the operator's release of the safe latch. The bench drives clr_safe high in the same cycle as a sample whose readings deviate too far. It then expects safe to stay 1 and the published value to be the safe code.

The bench also drives clr_safe together with a healthy sample. In that case it expects the latch to open and the average of that same sample to appear.

// File: rtl/rspv_pkg.sv
package rspv_pkg;
  typedef enum logic [1:0] {
    SEL_AVG  = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2,
    SEL_TRIP = 2'd3
  } sel_e;
endpackage

// File: rtl/rspv_range_chk.sv
module rspv_range_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned LO_LIM = 10376,
  parameter int unsigned HI_LIM = 55977
) (
  input  logic [W-1:0] code,
  output logic         flt
);
  localparam logic [W-1:0] LO_C = W'(LO_LIM);
  localparam logic [W-1:0] HI_C = W'(HI_LIM);

  always_comb begin
    flt = (code < LO_C) || (code > HI_C);
  end
endmodule

// File: rtl/rspv_fuse.sv
module rspv_fuse
  import rspv_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned DEV_LIM = 1311
) (
  input  logic [W-1:0] code_a,
  input  logic [W-1:0] code_b,
  input  logic         flt_a,
  input  logic         flt_b,
  output sel_e         sel,
  output logic [W-1:0] val,
  output logic         trip,
  output logic         one_flt
);
  localparam logic [W-1:0] DEV_C = W'(DEV_LIM);

  logic [W:0]   sum;
  logic [W-1:0] avg;
  logic [W-1:0] diff;
  logic         dev_bad;

  always_comb begin
    sum     = {1'b0, code_a} + {1'b0, code_b};
    avg     = W'(sum >> 1);
    diff    = (code_a > code_b) ? (code_a - code_b) : (code_b - code_a);
    dev_bad = diff > DEV_C;
  end

  always_comb begin
    unique case ({flt_a, flt_b})
      2'b00:   sel = dev_bad ? SEL_TRIP : SEL_AVG;
      2'b01:   sel = SEL_A;
      2'b10:   sel = SEL_B;
      default: sel = SEL_TRIP;
    endcase
  end

  always_comb begin
    val     = '0;
    trip    = 1'b0;
    one_flt = 1'b0;
    case (sel)
      SEL_AVG:  val = avg;
      SEL_A:    begin val = code_a; one_flt = 1'b1; end
      SEL_B:    begin val = code_b; one_flt = 1'b1; end
      default:  trip = 1'b1;
    endcase
  end
endmodule

// File: rtl/rspv_out_reg.sv
module rspv_out_reg #(
  parameter int unsigned W        = 16,
  parameter int unsigned SAFE_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_safe,
  input  logic         smp_vld,
  input  logic [W-1:0] val_in,
  input  logic         trip,
  input  logic         one_flt,
  input  logic         flt_a_in,
  input  logic         flt_b_in,
  output logic [W-1:0] out_val,
  output logic         out_vld,
  output logic         flt_a,
  output logic         flt_b,
  output logic         alarm,
  output logic         safe
);
  localparam logic [W-1:0] SAFE_C = W'(SAFE_VAL);

  logic safe_nxt;

  always_comb begin
    safe_nxt = (smp_vld & trip) | (safe & ~clr_safe);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_val <= '0;
      out_vld <= 1'b0;
      flt_a   <= 1'b0;
      flt_b   <= 1'b0;
      alarm   <= 1'b0;
      safe    <= 1'b0;
    end else begin
      safe    <= safe_nxt;
      out_vld <= smp_vld;
      if (smp_vld) begin
        out_val <= safe_nxt ? SAFE_C : val_in;
        flt_a   <= flt_a_in;
        flt_b   <= flt_b_in;
        alarm   <= one_flt;
      end
    end
  end

  // R7: the latch holds unless released
  p_safe_hold_r7: assert property (@(posedge clk) disable iff (rst)
    safe && !clr_safe |=> safe);

  // R7: a trip beats a simultaneous release
  p_trip_wins_r7: assert property (@(posedge clk) disable iff (rst)
    smp_vld && trip |=> safe);

  // R7: samples published in the safe state carry the safe code
  p_safe_code_r7: assert property (@(posedge clk) disable iff (rst)
    safe && out_vld |-> out_val == SAFE_C);

  // R8: out_vld is high for one cycle after each strobe
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> out_vld);
  p_vld_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !out_vld);

  // R8: published data holds between strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(out_val) && $stable(alarm) && $stable(flt_a) && $stable(flt_b));
endmodule

// File: rtl/rspv_pair_validator.sv
module rspv_pair_validator
  import rspv_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned LO_LIM   = 10376,
  parameter int unsigned HI_LIM   = 55977,
  parameter int unsigned DEV_LIM  = 1311,
  parameter int unsigned SAFE_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_safe,
  input  logic         smp_vld,
  input  logic [15:0]  code_a,
  input  logic [15:0]  code_b,
  output logic [15:0]  out_val,
  output logic         out_vld,
  output logic         flt_a,
  output logic         flt_b,
  output logic         alarm,
  output logic         safe
);
  localparam int unsigned NCH = 2;

  logic [W-1:0] codes [NCH];
  logic [NCH-1:0] flt_c;
  sel_e         sel;
  logic [W-1:0] fused;
  logic         trip;
  logic         one_flt;

  always_comb begin
    codes[0] = W'(code_a);
    codes[1] = W'(code_b);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    rspv_range_chk #(
      .W(W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)
    ) u_chk (
      .code (codes[ch]),
      .flt  (flt_c[ch])
    );
  end

  rspv_fuse #(
    .W(W), .DEV_LIM(DEV_LIM)
  ) u_fuse (
    .code_a  (codes[0]),
    .code_b  (codes[1]),
    .flt_a   (flt_c[0]),
    .flt_b   (flt_c[1]),
    .sel     (sel),
    .val     (fused),
    .trip    (trip),
    .one_flt (one_flt)
  );

  logic [W-1:0] out_w;

  rspv_out_reg #(
    .W(W), .SAFE_VAL(SAFE_VAL)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .clr_safe (clr_safe),
    .smp_vld  (smp_vld),
    .val_in   (fused),
    .trip     (trip),
    .one_flt  (one_flt),
    .flt_a_in (flt_c[0]),
    .flt_b_in (flt_c[1]),
    .out_val  (out_w),
    .out_vld  (out_vld),
    .flt_a    (flt_a),
    .flt_b    (flt_b),
    .alarm    (alarm),
    .safe     (safe)
  );

  always_comb out_val = 16'(out_w);

  // R4: both range checkers failing forces the safe state
  p_both_trip_r4: assert property (@(posedge clk) disable iff (rst)
    smp_vld && (&flt_c) |=> safe);

  // R3: alarm only with exactly one faulted channel
  p_alarm_one_r3: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (flt_a ^ flt_b));

  // R2: rail codes always fault under default limits
  p_rail_r2: assert property (@(posedge clk) disable iff (rst)
    smp_vld && (code_a == 16'h0000 || code_a == 16'hFFFF) |=> flt_a);

  // R3: single-fault selection matches the fault pattern
  p_sel_r3: assert property (@(posedge clk) disable iff (rst)
    smp_vld && (sel == SEL_A || sel == SEL_B) |-> (flt_c[0] ^ flt_c[1]));
endmodule

// File: tb/rspv_pair_validator_bench.sv
module rspv_pair_validator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_safe = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] code_a = '0;
  logic [15:0] code_b = '0;
  logic [15:0] out_val;
  logic        out_vld, flt_a, flt_b, alarm, safe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rspv_pair_validator u_rspv_pair_validator (
    .clk(clk), .rst(rst), .clr_safe(clr_safe), .smp_vld(smp_vld),
    .code_a(code_a), .code_b(code_b), .out_val(out_val), .out_vld(out_vld),
    .flt_a(flt_a), .flt_b(flt_b), .alarm(alarm), .safe(safe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one strobe, sample the registered result one cycle later
  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic clr);
    @(negedge clk);
    code_a = a; code_b = b; smp_vld = 1'b1; clr_safe = clr;
    @(negedge clk);
    smp_vld = 1'b0; clr_safe = 1'b0;
  endtask

  task automatic expect_out(input string req, input int v, input int fa, input int fb,
                            input int al, input int sf);
    chk({req, " out_vld"}, out_vld, 1);
    chk({req, " out_val"}, out_val, v);
    chk({req, " flt_a"}, flt_a, fa);
    chk({req, " flt_b"}, flt_b, fb);
    chk({req, " alarm"}, alarm, al);
    chk({req, " safe"}, safe, sf);
  endtask

  task automatic release_safe();
    @(negedge clk); clr_safe = 1'b1;
    @(negedge clk); clr_safe = 1'b0;
    chk("R7 release", safe, 0);
  endtask

  task automatic t_reset();
    chk("R9 out_val", out_val, 0);
    chk("R9 out_vld", out_vld, 0);
    chk("R9 flags", {flt_a, flt_b, alarm, safe}, 0);
  endtask

  task automatic t_average();
    send(16'd30000, 16'd30001, 1'b0); expect_out("R5 trunc", 30000, 0, 0, 0, 0);
    send(16'd10376, 16'd10376, 1'b0); expect_out("R1 R5 low edge", 10376, 0, 0, 0, 0);
    send(16'd55977, 16'd54666, 1'b0); expect_out("R5 dev at limit", 55321, 0, 0, 0, 0);
  endtask

  task automatic t_single_fault();
    send(16'd10375, 16'd20000, 1'b0); expect_out("R1 R3 low A", 20000, 1, 0, 1, 0);
    send(16'd20000, 16'd55978, 1'b0); expect_out("R1 R3 high B", 20000, 0, 1, 1, 0);
    send(16'd0, 16'd40000, 1'b0);     expect_out("R2 R3 zero A", 40000, 1, 0, 1, 0);
    send(16'd40000, 16'hFFFF, 1'b0);  expect_out("R2 R3 ones B", 40000, 0, 1, 1, 0);
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R8 no pulse", out_vld, 0);
    chk("R8 hold val", out_val, 40000);
    chk("R8 hold alarm", alarm, 1);
  endtask

  task automatic t_deviation();
    send(16'd20000, 16'd21312, 1'b0); expect_out("R6 trip", 0, 0, 0, 0, 1);
    send(16'd30000, 16'd30000, 1'b0); expect_out("R7 latched", 0, 0, 0, 0, 1);
    release_safe();
    chk("R7 release keeps val", out_val, 0);
    send(16'd30000, 16'd30002, 1'b0); expect_out("R7 after release", 30001, 0, 0, 0, 0);
  endtask

  task automatic t_both();
    send(16'd0, 16'hFFFF, 1'b0); expect_out("R4 both", 0, 1, 1, 0, 1);
    release_safe();
  endtask

  task automatic t_collide();
    send(16'd20000, 16'd25000, 1'b1); expect_out("R7 trip beats clear", 0, 0, 0, 0, 1);
    send(16'd30000, 16'd30010, 1'b1); expect_out("R7 clear with sample", 30005, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_average();
    t_single_fault();
    t_hold();
    t_deviation();
    t_both();
    t_collide();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule